// File: doc/BRIEF.md
# Sample Clock Divider with Phase Delay

This block turns a fast reference clock into a periodic, single-cycle sample strobe for a converter front end. A programmable divider value sets the strobe rate. A 4-bit delay code sets the strobe phase. Each delay step is one reference-clock cycle and stands for one 150 ps unit in the physical target, so code 15 gives the largest shift (2250 ps) and code 0 gives none.

Software-style writes load new divider and delay values into a pending stage. The running generator takes those values only at the end of its current period, so a period is never cut short. A status byte reports readiness on bit 7. The bit drops right after a write. It rises again once the first strobe produced with the new settings has been emitted, so firmware can poll it after every reconfiguration.

Top module: `smp_clk_div`

## Requirements
- R1: `rst_n` is asynchronous and active low. The internal reset releases on the second rising edge of `clk_ref` after `rst_n` goes high. While the internal reset is held, `smp_strobe` is 0 and `clk_status` reads 0x80. After release, the divider is 3, the delay code is 0, the ready bit is 1, and the first strobe appears in the first cycle after release.
- R2: With an active divider value N, the undelayed tick repeats every N+1 reference cycles. N = 0 gives a strobe in every cycle.
- R3: With an active delay code D, each strobe comes exactly D cycles after its undelayed tick. D = 0 gives no shift and D = 15 gives the maximum shift.
- R4: A write with `cfg_we`=1 and `cfg_sel`=0 sets the pending divider to all 8 bits of `cfg_wdata`. A write with `cfg_sel`=1 sets the pending delay code to `cfg_wdata[3:0]`, and bits 7:4 are ignored.
- R5: Pending values become active only in the cycle that ends a period, when the period count equals the active divider. The period in progress finishes with the old settings.
- R6: In the cycle after any write, `clk_status[7]` is 0.
- R7: After the last write, `clk_status[7]` returns to 1 in the cycle after the first strobe whose tick began a period under the newly loaded settings.
- R8: A write made while a reload is still pending or waiting for its strobe restarts the reload. Ready stays 0 until the strobe that belongs to the latest settings.
- R9: `clk_status[6:0]` always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Target of the write: 0 divider, 1 delay code |
| cfg_wdata | input | 8 | Write data |
| smp_strobe | output | 1 | Delayed sample strobe, one cycle wide |
| clk_status | output | 8 | Status byte, bit 7 is the ready bit |

## Verification
The bench sweeps the delay code to 0, 15 and values in between. It also runs the divider down to 0, where a design that decoded the tap off by one or mishandled the zero-delay bypass would shift every strobe by one cycle or lose it. A long period is reprogrammed mid-way: a design that applied settings at once would produce a short, runt period.

Bursts of writes land at scattered offsets, including during the wait for the confirming strobe. A design that forgot to discard the earlier reload's marker would raise ready too early, on a strobe that still uses the old phase. Writes to the delay code carry junk in the upper data bits, which catches a design that does not mask those bits.

// File: rtl/smp_clk_div_pkg.sv
`timescale 1ns/1ps
package smp_clk_div_pkg;
  typedef enum logic {
    TGT_DIV = 1'b0,
    TGT_DLY = 1'b1
  } cfg_tgt_e;

  localparam int STATUS_W = 8;
  localparam int RDY_BIT  = 7;
endpackage

// File: rtl/smp_rst_sync.sv
`timescale 1ns/1ps
module smp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/smp_period_gen.sv
`timescale 1ns/1ps
module smp_period_gen #(
  parameter int          DIV_W   = 8,
  parameter int          DLY_W   = 4,
  parameter logic [7:0]  DIV_RST = 8'd3,
  parameter logic [3:0]  DLY_RST = 4'd0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_pend,
  input  logic [DLY_W-1:0] dly_pend,
  output logic             bnd,
  output logic             tick,
  output logic [DLY_W-1:0] dly_act
);
  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [DLY_W-1:0] dly_q, dly_d;
  logic             load_en;

  assign bnd     = (cnt_q == div_q);
  assign tick    = (cnt_q == '0);
  assign load_en = bnd;
  assign dly_act = dly_q;

  // next state
  always_comb begin
    cnt_d = bnd ? '0 : cnt_q + 1'b1;
    div_d = div_pend;
    dly_d = dly_pend;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= DIV_W'(DIV_RST);
      dly_q <= DLY_W'(DLY_RST);
    end else begin
      cnt_q <= cnt_d;
      if (load_en) begin
        div_q <= div_d;
        dly_q <= dly_d;
      end
    end
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bnd |=> tick); // R2
  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div_q != '0) |=> !tick); // R2
  AST_HOLD_MIDPERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    !bnd |=> ($stable(div_q) && $stable(dly_q))); // R5
endmodule

// File: rtl/smp_phase_delay.sv
`timescale 1ns/1ps
module smp_phase_delay #(
  parameter int DLY_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             mark_in,
  input  logic             mark_clr,
  input  logic [DLY_W-1:0] dly,
  output logic             strobe_raw,
  output logic             mark_out
);
  localparam int LINE = (1 << DLY_W) - 1;

  logic [LINE-1:0]  tick_q, tick_d;
  logic [LINE-1:0]  mark_q, mark_d;
  logic [DLY_W-1:0] tap;

  assign tap = dly - 1'b1;

  always_comb begin
    tick_d = {tick_q[LINE-2:0], tick};
    mark_d = mark_clr ? '0 : {mark_q[LINE-2:0], mark_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      mark_q <= '0;
    end else begin
      tick_q <= tick_d;
      mark_q <= mark_d;
    end
  end

  always_comb begin
    if (dly == '0) begin
      strobe_raw = tick;
      mark_out   = mark_in;
    end else begin
      strobe_raw = tick_q[tap];
      mark_out   = mark_q[tap];
    end
  end

  AST_MARK_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    mark_out |-> strobe_raw); // R7
endmodule

// File: rtl/smp_clk_div.sv
`timescale 1ns/1ps
module smp_clk_div
  import smp_clk_div_pkg::*;
#(
  parameter int         DIV_W   = 8,
  parameter int         DLY_W   = 4,
  parameter logic [7:0] DIV_RST = 8'd3,
  parameter logic [3:0] DLY_RST = 4'd0
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [DIV_W-1:0] cfg_wdata,
  output logic             smp_strobe,
  output logic [7:0]       clk_status
);
  logic             rst_i_n;
  logic [DIV_W-1:0] div_p_q, div_p_d;
  logic [DLY_W-1:0] dly_p_q, dly_p_d;
  logic             pend_q, pend_d;
  logic             fresh_q, fresh_d;
  logic             rdy_q, rdy_d;
  logic             bnd, tick, strobe_raw, mark_out;
  logic [DLY_W-1:0] dly_act;
  cfg_tgt_e         tgt;

  assign tgt = cfg_tgt_e'(cfg_sel);

  smp_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  smp_period_gen #(
    .DIV_W(DIV_W), .DLY_W(DLY_W), .DIV_RST(DIV_RST), .DLY_RST(DLY_RST)
  ) u_per (
    .clk      (clk_ref),
    .rst_n    (rst_i_n),
    .div_pend (div_p_q),
    .dly_pend (dly_p_q),
    .bnd      (bnd),
    .tick     (tick),
    .dly_act  (dly_act)
  );

  smp_phase_delay #(.DLY_W(DLY_W)) u_dly (
    .clk        (clk_ref),
    .rst_n      (rst_i_n),
    .tick       (tick),
    .mark_in    (fresh_q),
    .mark_clr   (cfg_we),
    .dly        (dly_act),
    .strobe_raw (strobe_raw),
    .mark_out   (mark_out)
  );

  // next state
  always_comb begin
    div_p_d = div_p_q;
    dly_p_d = dly_p_q;
    if (cfg_we && tgt == TGT_DIV) div_p_d = cfg_wdata;
    if (cfg_we && tgt == TGT_DLY) dly_p_d = cfg_wdata[DLY_W-1:0];
    pend_d  = cfg_we ? 1'b1 : (bnd ? 1'b0 : pend_q);
    fresh_d = bnd && pend_q && !cfg_we;
    rdy_d   = cfg_we ? 1'b0 : (mark_out ? 1'b1 : rdy_q);
  end

  // registers
  always_ff @(posedge clk_ref or negedge rst_i_n) begin
    if (!rst_i_n) begin
      div_p_q <= DIV_W'(DIV_RST);
      dly_p_q <= DLY_W'(DLY_RST);
      pend_q  <= 1'b0;
      fresh_q <= 1'b0;
      rdy_q   <= 1'b1;
    end else begin
      div_p_q <= div_p_d;
      dly_p_q <= dly_p_d;
      pend_q  <= pend_d;
      fresh_q <= fresh_d;
      rdy_q   <= rdy_d;
    end
  end

  assign smp_strobe = rst_i_n & strobe_raw;

  always_comb begin
    clk_status          = '0;
    clk_status[RDY_BIT] = rdy_q;
  end

  AST_RDY_DROP: assert property (@(posedge clk_ref) disable iff (!rst_i_n)
    cfg_we |=> !clk_status[RDY_BIT]); // R6
  AST_RDY_RISE: assert property (@(posedge clk_ref) disable iff (!rst_i_n)
    $rose(clk_status[RDY_BIT]) |-> $past(smp_strobe)); // R7
  AST_PEND_BLOCKS_RDY: assert property (@(posedge clk_ref) disable iff (!rst_i_n)
    (pend_q && !bnd) |=> !clk_status[RDY_BIT]); // R8
endmodule

// File: tb/sim_smp_clk_div.sv
`timescale 1ns/1ps
module sim_smp_clk_div;
  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic       cfg_sel;
  logic [7:0] cfg_wdata;
  logic       smp_strobe;
  logic [7:0] clk_status;

  always #2 clk_ref = ~clk_ref;

  smp_clk_div u0 (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .smp_strobe (smp_strobe),
    .clk_status (clk_status)
  );

  int    n_chk = 0;
  int    n_bad = 0;
  string phase = "R1";
  bit    done  = 0;

  // behavioural reference model
  int edges, cyc;
  int m_cnt, m_div, m_dly, p_div, p_dly, mark_t;
  bit m_pend, m_fresh, m_rdy, m_hit;
  int ticks[$];

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  always @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      edges = 0; cyc = 0;
      m_cnt = 0; m_div = 3; m_dly = 0; p_div = 3; p_dly = 0;
      m_pend = 0; m_fresh = 0; m_rdy = 1; m_hit = 0; mark_t = -1;
      ticks.delete();
    end else begin
      edges++;
      if (edges >= 3) begin
        bit bnd;
        bnd     = (m_cnt == m_div);
        m_rdy   = cfg_we ? 1'b0 : (m_hit ? 1'b1 : m_rdy);
        m_fresh = bnd && m_pend && !cfg_we;
        m_pend  = cfg_we ? 1'b1 : (bnd ? 1'b0 : m_pend);
        if (bnd) begin m_div = p_div; m_dly = p_dly; m_cnt = 0; end
        else m_cnt++;
        if (cfg_we) begin
          if (!cfg_sel) p_div = cfg_wdata;
          else          p_dly = cfg_wdata & 8'h0F;
          mark_t = -1;
        end
        cyc++;
      end
    end
  end

  always @(negedge clk_ref) begin
    if (!rst_n || (rst_n && edges < 2)) begin
      check(smp_strobe == 1'b0, "R1", smp_strobe, 0);
      check(clk_status == 8'h80, "R1", clk_status, 8'h80);
    end else begin
      bit exp_stb;
      if (m_cnt == 0) ticks.push_back(cyc);
      if (m_fresh) mark_t = cyc;
      while (ticks.size() > 0 && ticks[0] < cyc - 20) void'(ticks.pop_front());
      exp_stb = 0;
      foreach (ticks[i]) if (ticks[i] == cyc - m_dly) exp_stb = 1;
      m_hit = (mark_t >= 0) && (cyc - m_dly == mark_t);
      check(smp_strobe == exp_stb, phase, smp_strobe, exp_stb);
      check(clk_status[7] == m_rdy, m_rdy ? "R7" : "R6", clk_status[7], m_rdy);
      check(clk_status[6:0] == 7'd0, "R9", clk_status[6:0], 0);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk_ref);
  endtask

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk_ref);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk_ref);
    cfg_we = 1'b0; cfg_wdata = 8'h00;
  endtask

  task automatic wait_rdy();
    int k;
    k = 0;
    while (clk_status[7] !== 1'b1 && k < 600) begin
      @(negedge clk_ref); k++;
    end
    check(k < 600, "R7", k, 600);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = 8'h00;
    idle(5);
    rst_n = 1'b1;
    idle(12);
    phase = "R2"; idle(20);
    phase = "R4";
    wr(0, 8'd5);  wait_rdy(); idle(20);
    wr(1, 8'hF3); wait_rdy(); idle(20);
    phase = "R3";
    wr(1, 8'h0F); wait_rdy(); idle(40);
    wr(1, 8'h07); wait_rdy(); idle(30);
    wr(1, 8'h00); wait_rdy(); idle(20);
    phase = "R2";
    wr(0, 8'd0); wr(1, 8'h02); wait_rdy(); idle(20);
    wr(1, 8'h00); wait_rdy(); idle(10);
    wr(1, 8'h0F); wait_rdy(); idle(30);
    phase = "R5";
    wr(1, 8'h00); wr(0, 8'd40); wait_rdy(); idle(10);
    wr(0, 8'd2); idle(60); wait_rdy(); idle(10);
    phase = "R8";
    wr(0, 8'd9); idle(1); wr(1, 8'h05); idle(12); wr(1, 8'h01);
    wait_rdy(); idle(20);
    begin
      int s;
      s = 7;
      for (int i = 0; i < 40; i++) begin
        s = (s * 37 + 11) % 101;
        wr(s[0], 8'(s % 13));
        idle(s % 19);
      end
    end
    wait_rdy(); idle(40);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_ref);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule